// File: doc/BRIEF.md
# Filter Pipeline Bus Wrapper

This block sits between a processor-side register bus and an image filter chain made of a smoothing stage followed by an edge stage. Software writes prepared frame data as a linear stream of 16-bit words to a data register. Each word holds two 8-bit pixels. The words queue in an input FIFO, and an unpacker presents them to the filter chain one pixel at a time. On the way back, the wrapper takes pixels from one of two taps on the chain: the smoothed output, or the binary edge result. It packs them two to a word into an output FIFO, and software reads that FIFO back through the same data register.

A control register selects which tap is returned and provides a soft flush. A status register reports whether the input FIFO is full, whether the output FIFO is empty, and how many words the output FIFO holds. The bus never drops data. A data write that finds the input FIFO full, or a data read that finds the output FIFO empty, holds the wait-request line high until it can complete.

The filter side is a single-enable stream. While the wrapper raises the advance enable, every filter stage shifts by one position. On that same edge the wrapper takes the pixel it offers if it is valid, and it consumes the selected tap if that tap is valid. When the advance enable is low, the pixel offered and both taps must stay exactly as they are. The enable drops whenever the output FIFO has no room for another word.

Top module: `filt_wrap`

## Requirements
- R1: After reset, wait-request is low when the bus is idle, the control register reads 0x0000, and the status register reads 0x0002 (output FIFO empty, output count 0).
- R2: Each input word is delivered as two pixels, bits [7:0] first and then bits [15:8]. An offered pixel holds its value while the advance enable is low.
- R3: Returned pixels are packed two per word, with the first pixel in bits [7:0] and the second in bits [15:8]. Words are read back in the order they were formed.
- R4: Control bit 0 equal to 0 returns the smoothed tap. Control bit 0 equal to 1 returns the edge tap, with edge bit 1 mapped to byte 0xFF and edge bit 0 mapped to 0x00.
- R5: A write to the data register (address 0) while the input FIFO is full holds wait-request high and stores nothing until it completes. No written word is lost or duplicated.
- R6: A read from the data register while the output FIFO is empty holds wait-request high until a word is available, and then returns that word.
- R7: The advance enable is low whenever the output FIFO holds FIFO_WORDS words. While it is low, the output word count does not grow.
- R8: Writing the control register (address 1) with bit 1 set empties both FIFOs and clears the unpack and pack state. Bit 0 of the same write sets the select, bit 1 always reads back as 0, and the select value remains in effect after the flush.
- R9: The status register (address 2) carries the input-full flag in bit 0, the output-empty flag in bit 1, and the output word count in bits [15:4].
- R10: The input FIFO accepts exactly FIFO_WORDS words before it reports full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_write | input | 1 | Write strobe |
| bus_read | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while a read is not waiting |
| bus_wait | output | 1 | Wait-request; the access completes on the first edge at which it is low |
| flt_adv | output | 1 | Advance enable for every filter stage |
| pix_valid | output | 1 | A pixel is offered to the smoothing stage |
| pix_data | output | 8 | Offered pixel |
| smooth_valid | input | 1 | Smoothed tap holds a pixel |
| smooth_pix | input | 8 | Smoothed tap pixel |
| edge_valid | input | 1 | Edge tap holds a result |
| edge_bit | input | 1 | Edge tap result |

## Verification
The hardest state to reach is back-pressure that runs all the way through the chain. The output FIFO has to be full so that the filter stalls, the unpacker has to be holding a word, and the input FIFO has to be full behind it, all before a further write is attempted. The bench builds the wrapper with a small FIFO depth and writes without reading until the status shows the output FIFO full and then the input FIFO full. It then attempts one more write, abandons it after a bounded wait, and reads everything back to confirm that no word was lost or duplicated.

// File: rtl/filt_wrap_pkg.sv
package filt_wrap_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  localparam int CTRL_SEL_BIT   = 0;
  localparam int CTRL_FLUSH_BIT = 1;
  localparam int STAT_CNT_W     = 12;
endpackage

// File: rtl/wrap_fifo.sv
module wrap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2400,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wrap_unpack.sv
module wrap_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        src_empty,
  input  logic [15:0] src_word,
  output logic        src_pop,
  input  logic        adv,
  output logic        pix_valid,
  output logic [7:0]  pix_data
);
  logic [15:0] held;
  logic        have, upper;
  logic        take;

  assign pix_valid = have;
  assign pix_data  = upper ? held[15:8] : held[7:0];
  assign take      = have && adv;
  assign src_pop   = !src_empty && (!have || (take && upper));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      held  <= '0;
      have  <= 1'b0;
      upper <= 1'b0;
    end else if (src_pop) begin
      held  <= src_word;
      have  <= 1'b1;
      upper <= 1'b0;
    end else if (take) begin
      if (upper) begin
        have  <= 1'b0;
        upper <= 1'b0;
      end else begin
        upper <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrap_pack.sv
module wrap_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        take,
  input  logic [7:0]  px,
  output logic        push,
  output logic [15:0] word
);
  logic [7:0] first;
  logic       have_first;

  assign push = take && have_first;
  assign word = {px, first};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      first      <= '0;
      have_first <= 1'b0;
    end else if (take) begin
      if (!have_first) first <= px;
      have_first <= !have_first;
    end
  end
endmodule

// File: rtl/filt_wrap.sv
module filt_wrap
  import filt_wrap_pkg::*;
#(
  parameter int FIFO_WORDS = 2400,
  localparam int CW = $clog2(FIFO_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_write,
  input  logic        bus_read,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_wait,
  output logic        flt_adv,
  output logic        pix_valid,
  output logic [7:0]  pix_data,
  input  logic        smooth_valid,
  input  logic [7:0]  smooth_pix,
  input  logic        edge_valid,
  input  logic        edge_bit
);
  logic          sel_edge;
  logic          wr_data, rd_data, wr_ctrl, flush;
  logic          in_push, in_pop, in_full, in_empty;
  logic          out_push, out_pop, out_full, out_empty;
  logic [15:0]   in_head, out_head, packed_word;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          tap_valid, tap_take;
  logic [7:0]    tap_px;

  assign wr_data  = bus_write && (bus_addr == REG_DATA);
  assign rd_data  = bus_read  && (bus_addr == REG_DATA);
  assign wr_ctrl  = bus_write && (bus_addr == REG_CTRL);
  assign flush    = wr_ctrl && bus_wdata[CTRL_FLUSH_BIT];

  assign bus_wait = (wr_data && in_full) || (rd_data && out_empty);
  assign in_push  = wr_data && !in_full;
  assign out_pop  = rd_data && !out_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_edge <= 1'b0;
    else if (wr_ctrl) sel_edge <= bus_wdata[CTRL_SEL_BIT];
  end

  always_comb begin
    case (bus_addr)
      REG_DATA: bus_rdata = out_head;
      REG_CTRL: bus_rdata = {15'd0, sel_edge};
      REG_STAT: bus_rdata = {STAT_CNT_W'(out_cnt), 2'b00, out_empty, in_full};
      default:  bus_rdata = '0;
    endcase
  end

  assign flt_adv   = !out_full;
  assign tap_valid = sel_edge ? edge_valid : smooth_valid;
  assign tap_px    = sel_edge ? {8{edge_bit}} : smooth_pix;
  assign tap_take  = flt_adv && tap_valid;

  wrap_fifo #(.W(16), .DEPTH(FIFO_WORDS)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(in_push), .din(bus_wdata), .pop(in_pop),
    .dout(in_head), .full(in_full), .empty(in_empty), .count(in_cnt)
  );

  wrap_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .src_empty(in_empty), .src_word(in_head), .src_pop(in_pop),
    .adv(flt_adv), .pix_valid(pix_valid), .pix_data(pix_data)
  );

  wrap_pack u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(tap_take), .px(tap_px), .push(out_push), .word(packed_word)
  );

  wrap_fifo #(.W(16), .DEPTH(FIFO_WORDS)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(out_push), .din(packed_word), .pop(out_pop),
    .dout(out_head), .full(out_full), .empty(out_empty), .count(out_cnt)
  );
endmodule

// File: rtl/filt_wrap_checks.sv
module filt_wrap_checks #(
  parameter int DEPTH = 2400,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_write,
  input logic          bus_read,
  input logic [15:0]   bus_wdata,
  input logic          bus_wait,
  input logic          flt_adv,
  input logic          pix_valid,
  input logic [7:0]    pix_data,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt
);
  logic soft_flush;
  assign soft_flush = bus_write && (bus_addr == 2'd1) && bus_wdata[1];

  assert_pix_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !flt_adv && !soft_flush) |=> (pix_valid && $stable(pix_data)));

  assert_write_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == 2'd0 && in_cnt == CW'(DEPTH)) |-> bus_wait);

  assert_read_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && bus_addr == 2'd0 && out_cnt == '0) |-> bus_wait);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_adv |=> (out_cnt <= $past(out_cnt)));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_flush |=> (in_cnt == '0 && out_cnt == '0));

  assert_in_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CW'(DEPTH));
endmodule

bind filt_wrap filt_wrap_checks #(.DEPTH(FIFO_WORDS)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
  .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
  .flt_adv(flt_adv), .pix_valid(pix_valid), .pix_data(pix_data),
  .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/test_filt_wrap.sv
`timescale 1ns/1ps
module test_filt_wrap;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_write = 1'b0, bus_read = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_wait, flt_adv, pix_valid;
  logic [7:0]  pix_data;
  logic        s_v, e_v, e_b;
  logic [7:0]  s_d;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  pix_log[$];
  bit          sel_edge_tb = 1'b0;

  always #4 clk = ~clk;

  filt_wrap #(.FIFO_WORDS(DEPTH)) i_filt_wrap (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .flt_adv(flt_adv), .pix_valid(pix_valid),
    .pix_data(pix_data), .smooth_valid(s_v), .smooth_pix(s_d),
    .edge_valid(e_v), .edge_bit(e_b)
  );

  // pass-through filter stubs: smoothing copies, edge thresholds on bit 7
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v <= 1'b0; s_d <= '0; e_v <= 1'b0; e_b <= 1'b0;
    end else if (flt_adv) begin
      s_v <= pix_valid; s_d <= pix_data;
      e_v <= s_v;       e_b <= s_d[7];
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && pix_valid && flt_adv) pix_log.push_back(pix_data);
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic [1:0] a, input bit wr, input logic [15:0] wd,
                          input int maxwait, output logic [15:0] rd,
                          output int waits, output bit done);
    @(negedge clk);
    bus_addr = a; bus_write = wr; bus_read = !wr; bus_wdata = wd;
    waits = 0; done = 1'b1;
    #1;
    while (bus_wait) begin
      if (waits >= maxwait) begin done = 1'b0; break; end
      waits++;
      @(negedge clk); #1;
    end
    rd = bus_rdata;
    if (done) @(posedge clk);
    #1;
    bus_write = 1'b0; bus_read = 1'b0;
  endtask

  function automatic logic [15:0] expect_word(input logic [15:0] w);
    if (!sel_edge_tb) return w;
    return {(w[15] ? 8'hFF : 8'h00), (w[7] ? 8'hFF : 8'h00)};
  endfunction

  // driver: writes a data word and pushes the predicted result
  task automatic drive_word(input logic [15:0] w);
    logic [15:0] rd; int wt; bit ok;
    bus_xfer(2'd0, 1'b1, w, 1000, rd, wt, ok);
    exp_q.push_back(expect_word(w));
  endtask

  // monitor: reads result words and compares against the scoreboard
  task automatic monitor_words(input int n, input string req);
    logic [15:0] rd, e; int wt; bit ok;
    for (int i = 0; i < n; i++) begin
      bus_xfer(2'd0, 1'b0, 16'h0, 1000, rd, wt, ok);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
      chk(ok && rd === e, req, rd, e);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
    int wt; bit ok;
    bus_xfer(a, 1'b0, 16'h0, 10, v, wt, ok);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] v);
    logic [15:0] rd; int wt; bit ok;
    bus_xfer(a, 1'b1, v, 10, rd, wt, ok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, rd;
    int wt; bit ok;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    #1 chk(bus_wait == 1'b0, "R1 idle wait", {15'd0, bus_wait}, 16'h0);
    reg_read(2'd1, v); chk(v == 16'h0000, "R1 control", v, 16'h0000);
    reg_read(2'd2, v); chk(v == 16'h0002, "R1 status", v, 16'h0002);

    // R2/R3 smoothing pass, order and packing
    pix_log.delete();
    drive_word(16'hA112); drive_word(16'h3456);
    drive_word(16'h0F80); drive_word(16'hC3E7);
    repeat (20) @(negedge clk);
    chk(pix_log.size() == 8, "R2 pixel count", 16'(pix_log.size()), 16'd8);
    if (pix_log.size() >= 4) begin
      chk(pix_log[0] == 8'h12, "R2 low byte first", {8'h0, pix_log[0]}, 16'h0012);
      chk(pix_log[1] == 8'hA1, "R2 high byte second", {8'h0, pix_log[1]}, 16'h00A1);
      chk(pix_log[2] == 8'h56, "R2 next word low", {8'h0, pix_log[2]}, 16'h0056);
    end
    reg_read(2'd2, v); chk(v == 16'h0040, "R9 status count 4", v, 16'h0040);
    monitor_words(4, "R3 packed smooth words");

    // R6 read waits on empty output
    drive_word(16'h5AA5);
    bus_xfer(2'd0, 1'b0, 16'h0, 1000, rd, wt, ok);
    v = exp_q.pop_front();
    chk(ok && wt > 0, "R6 read waited", 16'(wt), 16'd1);
    chk(rd == v, "R6 read data", rd, v);

    // R4 edge tap
    repeat (10) @(negedge clk);
    reg_write(2'd1, 16'h0001); sel_edge_tb = 1'b1;
    reg_read(2'd1, v); chk(v == 16'h0001, "R4 select readback", v, 16'h0001);
    drive_word(16'h7F80); drive_word(16'hFF00); drive_word(16'h0180);
    repeat (20) @(negedge clk);
    reg_read(2'd2, v); chk(v == 16'h0030, "R9 status count 3", v, 16'h0030);
    monitor_words(3, "R4 edge words");

    // R8 soft flush keeps select
    drive_word(16'h1111); drive_word(16'h2222);
    exp_q.delete();
    repeat (20) @(negedge clk);
    reg_write(2'd1, 16'h0003);
    reg_read(2'd2, v); chk(v == 16'h0002, "R8 flushed status", v, 16'h0002);
    reg_read(2'd1, v); chk(v == 16'h0001, "R8 select kept", v, 16'h0001);
    drive_word(16'h8001);
    monitor_words(1, "R8 edge after flush");

    // R7 / R10 / R5 back-pressure, smoothing mode
    repeat (10) @(negedge clk);
    reg_write(2'd1, 16'h0000); sel_edge_tb = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) drive_word(16'h1000 + 16'(i));
    repeat (30) @(negedge clk);
    #1 chk(flt_adv == 1'b0, "R7 stall when output full", {15'd0, flt_adv}, 16'h0);
    reg_read(2'd2, v); chk(v == 16'h0080, "R7 output full count", v, 16'h0080);
    for (int i = 0; i < DEPTH; i++) drive_word(16'h2000 + 16'(i));
    reg_read(2'd2, v); chk(v == 16'h0080, "R10 not full before capacity", v, 16'h0080);
    drive_word(16'h3000);
    reg_read(2'd2, v); chk(v == 16'h0081, "R10 full at capacity", v, 16'h0081);
    bus_xfer(2'd0, 1'b1, 16'h3001, 20, rd, wt, ok);
    chk(!ok && wt == 20, "R5 write held by wait", 16'(wt), 16'd20);
    monitor_words(2 * DEPTH + 1, "R5 no loss under back-pressure");
    drive_word(16'h3001);
    monitor_words(1, "R5 retried write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule